// File: doc/BRIEF.md
# Predicate Guard for Late Instruction Annulment

This block keeps a bank of single-bit predicate registers and uses them to decide, at the end of the pipeline, whether an instruction may change state. A compare operation reports its outcome on a write port, and that outcome lands in two predicate registers at once: the condition goes to one target and its complement goes to the other.

Each instruction that reaches the writeback stage presents the index of its guarding predicate and a flag saying whether its execution faulted. One cycle later the block raises a commit enable if the guard is true. It raises an exception enable only if the guard is true and the instruction faulted. An instruction with a false guard becomes a no-op. It changes no state, and any fault it picked up, such as a protection or page fault, is dropped.

Because the decision is made this late, annulled instructions have already used their functional units. Predicate 0 always reads true, so instructions that are not predicated can name it.

Top module: `pred_guard`

## Requirements
- R1: After a synchronous reset, predicates 1 to N-1 read false, and both outputs are low in the first cycle after reset.
- R2: A compare write (`cmp_valid` high) sets predicate `cmp_idx_t` to `cmp_cond` and predicate `cmp_idx_f` to the inverse of `cmp_cond`. Later qualifies see these values.
- R3: Predicate 0 always reads true. A compare write that targets index 0 has no effect on it.
- R4: A qualify (`q_valid` high) whose guard is true drives `commit_en` high in the next cycle.
- R5: A qualify whose guard is false drives `commit_en` and `raise_exc` low in the next cycle, even when `q_fault` is high.
- R6: A qualify whose guard is true drives `raise_exc` in the next cycle equal to `q_fault`.
- R7: With `q_valid` low, both outputs are low in the next cycle, whatever `q_fault` and `q_idx` are.
- R8: When a compare write and a qualify name the same predicate in the same cycle, the qualify uses the newly written value.
- R9: When `cmp_idx_t` equals `cmp_idx_f` (and is not 0), that predicate takes `cmp_cond`.
- R10: Predicates hold their value across cycles with no compare write that targets them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | 1 | Compare result write strobe |
| cmp_cond | input | 1 | Compare outcome |
| cmp_idx_t | input | 6 | Predicate that receives the outcome |
| cmp_idx_f | input | 6 | Predicate that receives the inverted outcome |
| q_valid | input | 1 | Instruction at writeback to qualify |
| q_idx | input | 6 | Guarding predicate index of that instruction |
| q_fault | input | 1 | Instruction faulted during execution |
| commit_en | output | 1 | Registered: allow architectural update |
| raise_exc | output | 1 | Registered: allow the fault to be raised |

## Verification
The first sweep qualifies all 64 indices straight after reset, with the fault flag set. This separates the hardwired predicate 0 from the cleared ones and shows that faults on false guards are masked. The bank is then filled through compare writes whose targets are computed from the index, with complement targets spread across the file, and a full faulted sweep shows that each register keeps the value written last. Targeted cycles cover a write and a read of the same index in one cycle (for both the true and the complement target), a write whose two targets are equal, writes aimed at predicate 0, and idle qualifies that carry a fault.

// File: rtl/pred_guard_pkg.sv
package pred_guard_pkg;
  typedef struct packed {
    logic commit;
    logic raise;
  } qual_res_t;
endpackage

// File: rtl/pred_bank.sv
module pred_bank #(
  parameter int NUM_PRED = 64,
  localparam int IW = $clog2(NUM_PRED)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                wr_cond,
  input  logic [IW-1:0]       wr_idx_t,
  input  logic [IW-1:0]       wr_idx_f,
  output logic [NUM_PRED-1:0] bits
);
  // Entry 0 is a constant true; the rest are individual flops so that two
  // targets can be written in one cycle.
  assign bits[0] = 1'b1;

  for (genvar g = 1; g < NUM_PRED; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        bits[g] <= 1'b0;
      end else if (wr_en && wr_idx_t == IW'(g)) begin
        bits[g] <= wr_cond;
      end else if (wr_en && wr_idx_f == IW'(g)) begin
        bits[g] <= ~wr_cond;
      end
    end
  end
endmodule

// File: rtl/pred_read.sv
module pred_read #(
  parameter int NUM_PRED = 64,
  localparam int IW = $clog2(NUM_PRED)
) (
  input  logic [NUM_PRED-1:0] bits,
  input  logic                wr_en,
  input  logic                wr_cond,
  input  logic [IW-1:0]       wr_idx_t,
  input  logic [IW-1:0]       wr_idx_f,
  input  logic [IW-1:0]       rd_idx,
  output logic                rd_val
);
  // Same-cycle forwarding; the true target overrides the complement target.
  always_comb begin
    rd_val = bits[rd_idx];
    if (wr_en && rd_idx == wr_idx_f) rd_val = ~wr_cond;
    if (wr_en && rd_idx == wr_idx_t) rd_val = wr_cond;
    if (rd_idx == '0) rd_val = 1'b1;
  end
endmodule

// File: rtl/pred_qualify.sv
module pred_qualify
  import pred_guard_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      valid,
  input  logic      guard,
  input  logic      fault,
  output qual_res_t res
);
  qual_res_t nxt;

  always_comb begin
    nxt.commit = valid & guard;
    nxt.raise  = valid & guard & fault;
  end

  always_ff @(posedge clk) begin
    if (rst) res <= '0;
    else     res <= nxt;
  end
endmodule

// File: rtl/pred_guard.sv
module pred_guard
  import pred_guard_pkg::*;
#(
  parameter int NUM_PRED = 64,
  localparam int IW = $clog2(NUM_PRED)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmp_valid,
  input  logic          cmp_cond,
  input  logic [IW-1:0] cmp_idx_t,
  input  logic [IW-1:0] cmp_idx_f,
  input  logic          q_valid,
  input  logic [IW-1:0] q_idx,
  input  logic          q_fault,
  output logic          commit_en,
  output logic          raise_exc
);
  logic [NUM_PRED-1:0] bank_bits;
  logic                guard;
  qual_res_t           res;

  pred_bank #(.NUM_PRED(NUM_PRED)) u_bank (
    .clk(clk), .rst(rst), .wr_en(cmp_valid), .wr_cond(cmp_cond),
    .wr_idx_t(cmp_idx_t), .wr_idx_f(cmp_idx_f), .bits(bank_bits)
  );

  pred_read #(.NUM_PRED(NUM_PRED)) u_read (
    .bits(bank_bits), .wr_en(cmp_valid), .wr_cond(cmp_cond),
    .wr_idx_t(cmp_idx_t), .wr_idx_f(cmp_idx_f), .rd_idx(q_idx),
    .rd_val(guard)
  );

  pred_qualify u_qual (
    .clk(clk), .rst(rst), .valid(q_valid), .guard(guard),
    .fault(q_fault), .res(res)
  );

  assign commit_en = res.commit;
  assign raise_exc = res.raise;
endmodule

// File: rtl/pred_guard_chk.sv
module pred_guard_chk #(
  parameter int NUM_PRED = 64,
  localparam int IW = $clog2(NUM_PRED)
) (
  input logic          clk,
  input logic          rst,
  input logic          cmp_valid,
  input logic          cmp_cond,
  input logic [IW-1:0] cmp_idx_t,
  input logic [IW-1:0] cmp_idx_f,
  input logic          q_valid,
  input logic [IW-1:0] q_idx,
  input logic          q_fault,
  input logic          commit_en,
  input logic          raise_exc
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!commit_en && !raise_exc));

  a_r5_exc_needs_commit: assert property (@(posedge clk) disable iff (rst)
    raise_exc |-> commit_en);

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !q_valid |=> (!commit_en && !raise_exc));

  a_r3_zero_commits: assert property (@(posedge clk) disable iff (rst)
    (q_valid && q_idx == '0) |=> commit_en);

  a_r6_fault_passes: assert property (@(posedge clk) disable iff (rst)
    (q_valid && q_idx == '0) |=> (raise_exc == $past(q_fault)));

  a_r8_bypass_true: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && q_valid && q_idx == cmp_idx_t && cmp_idx_t != '0)
      |=> (commit_en == $past(cmp_cond)));

  a_r2_bypass_compl: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && q_valid && q_idx == cmp_idx_f && cmp_idx_f != '0 &&
     cmp_idx_f != cmp_idx_t) |=> (commit_en == !$past(cmp_cond)));
endmodule

bind pred_guard pred_guard_chk #(.NUM_PRED(NUM_PRED)) u_chk (
  .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .cmp_cond(cmp_cond),
  .cmp_idx_t(cmp_idx_t), .cmp_idx_f(cmp_idx_f), .q_valid(q_valid),
  .q_idx(q_idx), .q_fault(q_fault), .commit_en(commit_en),
  .raise_exc(raise_exc)
);

// File: tb/sim_pred_guard.sv
module sim_pred_guard;
  logic       clk = 1'b0;
  logic       rst;
  logic       cmp_valid, cmp_cond, q_valid, q_fault;
  logic [5:0] cmp_idx_t, cmp_idx_f, q_idx;
  logic       commit_en, raise_exc;
  int         checks = 0;
  int         fails = 0;
  bit         model [64];

  always #2 clk = ~clk;

  pred_guard u0 (
    .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .cmp_cond(cmp_cond),
    .cmp_idx_t(cmp_idx_t), .cmp_idx_f(cmp_idx_f), .q_valid(q_valid),
    .q_idx(q_idx), .q_fault(q_fault), .commit_en(commit_en),
    .raise_exc(raise_exc)
  );

  task automatic check(string tag, logic ac, logic ae, logic xc, logic xe);
    checks++;
    if (ac !== xc || ae !== xe) begin
      fails++;
      $display("FAIL %s: commit=%b raise=%b expected commit=%b raise=%b",
               tag, ac, ae, xc, xe);
    end
  endtask

  // One cycle: drive at negedge, check registered outputs after the edge.
  task automatic cyc(string tag, bit cv, bit cc, int ti, int fi,
                     bit qv, int qi, bit qf);
    bit g, xc, xe;
    @(negedge clk);
    cmp_valid = cv; cmp_cond = cc; cmp_idx_t = 6'(ti); cmp_idx_f = 6'(fi);
    q_valid = qv; q_idx = 6'(qi); q_fault = qf;
    if (cv) begin
      if (fi != 0) model[fi] = ~cc;
      if (ti != 0) model[ti] = cc;
    end
    g  = (qi == 0) ? 1'b1 : model[qi];
    xc = qv & g;
    xe = qv & g & qf;
    @(posedge clk);
    #1;
    check(tag, commit_en, raise_exc, xc, xe);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 1'b0;
    rst = 1'b1; cmp_valid = 0; cmp_cond = 0; cmp_idx_t = 0; cmp_idx_f = 0;
    q_valid = 1; q_idx = 0; q_fault = 1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset outputs", commit_en, raise_exc, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    // R1/R3/R5: all cleared except index 0; faults masked on false guards.
    for (int i = 0; i < 64; i++) cyc("R1 R5 reset sweep", 0, 0, 0, 0, 1, i, 1);
    // R2: fill with computed pattern, complements spread across the file.
    for (int i = 1; i < 64; i++)
      cyc("R2 fill", 1, ((i * 5) % 3) == 0, i, (i * 7) % 64, 0, 0, 0);
    // R2/R10: full readback with faults, then without.
    for (int i = 0; i < 64; i++) cyc("R2 R6 readback fault", 0, 0, 0, 0, 1, i, 1);
    for (int i = 0; i < 64; i++) cyc("R4 R10 readback clean", 0, 0, 0, 0, 1, i, 0);
    // R3: writes aimed at predicate 0 are ignored.
    cyc("R3 write zero t", 1, 0, 0, 9, 1, 0, 1);
    cyc("R3 write zero f", 1, 1, 9, 0, 1, 0, 0);
    cyc("R3 read zero", 0, 0, 0, 0, 1, 0, 1);
    // R8: same-cycle bypass on true and complement targets.
    cyc("R8 bypass t=1", 1, 1, 20, 21, 1, 20, 1);
    cyc("R8 bypass t=0", 1, 0, 20, 21, 1, 20, 1);
    cyc("R8 bypass f", 1, 0, 30, 31, 1, 31, 1);
    cyc("R8 bypass f false", 1, 1, 30, 31, 1, 31, 1);
    // R9: equal targets take the condition.
    cyc("R9 equal targets 1", 1, 1, 40, 40, 1, 40, 0);
    cyc("R9 equal read", 0, 0, 0, 0, 1, 40, 1);
    cyc("R9 equal targets 0", 1, 0, 41, 41, 0, 0, 0);
    cyc("R9 equal read 0", 0, 0, 0, 0, 1, 41, 1);
    // R7: idle qualifies with fault and a true guard.
    cyc("R7 idle", 0, 0, 0, 0, 0, 40, 1);
    cyc("R7 idle zero", 0, 0, 0, 0, 0, 0, 1);
    // R10: final sweep.
    for (int i = 0; i < 64; i++) cyc("R10 final sweep", 0, 0, 0, 0, 1, i, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule